// File: doc/BRIEF.md
# Pattern Fill Engine

This block fills a span of physical memory with a repeating pattern and needs no further help from the processor once started. Software programs four word registers per channel: a first address, a limit address, a pattern value and a control word. Both addresses count in 8-byte units. Setting the start bit in the control word begins the fill. The channel then issues one aligned 32-bit write per clock on its own memory write port, from the first byte address up to the limit.

Three pattern widths are supported. A 16-bit pattern repeats the low half of the value. A 32-bit pattern repeats the whole value. A 24-bit pattern repeats three colour bytes, and because three bytes do not divide a 4-byte word, the byte phase rotates from word to word. When a channel finishes, its start bit clears and its finished flag sets. A one-cycle interrupt pulse is raised on that channel's own line, except when the first address is zero. A span whose limit is not above its first address writes nothing and sets an error flag instead.

The channels are independent copies. Each has its own registers, its own write port and its own interrupt line, so they may run at the same time.

Top module: `memfill_engine`

## Requirements
- R1: Register index bits [1:0] select first address (0), limit address (1), pattern value (2) or control (3). Write address bit 2 selects the channel. Both address registers count in 8-byte units. The first write goes to byte address first*8 and the last write goes to limit*8-4.
- R2: In 16-bit mode (control bits 9 and 8 both clear), every written word is {value[15:0], value[15:0]}.
- R3: Control bit 8 selects 24-bit mode even when bit 9 is also set. Bit 9 alone selects 32-bit mode, in which every written word equals the value.
- R4: In 24-bit mode, the byte k bytes past the first address receives value byte (k mod 3): bits 7:0, then 15:8, then 23:16. Byte lane i of a word (bits 8i+7:8i) lands at word address + i.
- R5: Writes start on the cycle after the control write that sets bit 0. They run one word per cycle at consecutive word addresses, with all four byte enables set, and no write is issued at or past the limit.
- R6: If the limit is not greater than the first address when start is written, nothing is written, control bit 2 (error) reads 1, bits 0 and 1 read 0 and no interrupt is raised.
- R7: On the cycle after the last write, control bit 0 reads 0 and bit 1 (finished) reads 1. This happens even when the first address is zero.
- R8: The channel's interrupt is a single-cycle pulse on the cycle after its last write, and it is raised only if the first address is non-zero.
- R9: The two channels run independently and can fill at the same time, each on its own write port and interrupt line.
- R10: While a channel is filling, its control bit 0 reads 1 and all register writes to that channel are ignored. After the fill its registers still hold the values it started with.
- R11: After reset all registers read 0 and no write is issued. A control write accepted while idle clears the finished and error flags and stores bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address: {channel, index} |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address: {channel, index} |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 2 | Memory write strobe, one per channel |
| mem_addr | output | 38 | Byte address of the written word, 19 bits per channel |
| mem_be | output | 8 | Byte enables, 4 per channel |
| mem_wdata | output | 64 | Write data, 32 bits per channel |
| irq | output | 2 | Completion interrupt pulse, one per channel |

## Verification
The assertions assume that the memory side accepts one write per cycle with no back-pressure. They also assume that software programs the address registers before writing the start bit, and that the limit address leaves headroom below the top of the byte address space. The stimulus keeps every span well inside the 16-bit unit range. It always writes the addresses before the control word, and it issues no register writes during the cycles in which a channel is completing. The only exception is a deliberate burst of writes during a long fill, which checks that they are ignored.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

    typedef enum logic [1:0] {
        FILL16 = 2'd0,
        FILL24 = 2'd1,
        FILL32 = 2'd2
    } fill_mode_e;

    typedef enum logic [1:0] {
        IDX_FIRST = 2'd0,
        IDX_LIMIT = 2'd1,
        IDX_VALUE = 2'd2,
        IDX_CTRL  = 2'd3
    } reg_idx_e;

    // sel = {control bit 9, control bit 8}; the 24-bit select wins
    function automatic fill_mode_e decode_mode(input logic [1:0] sel);
        if (sel[0])      return FILL24;
        else if (sel[1]) return FILL32;
        else             return FILL16;
    endfunction

endpackage

// File: rtl/memfill_lanes.sv
module memfill_lanes
    import memfill_pkg::*;
(
    input  fill_mode_e  mode,
    input  logic [31:0] value,
    input  logic [1:0]  phase,
    output logic [31:0] word,
    output logic [1:0]  phase_nxt
);
    localparam int LANES = 4;

    always_comb begin
        // byte phase of the following word: (phase + LANES) mod 3
        phase_nxt = 2'((int'(phase) + LANES) % 3);
        word      = '0;
        for (int i = 0; i < LANES; i++) begin
            case (mode)
                FILL16:  word[8*i +: 8] = value[8*(i%2) +: 8];
                FILL24:  word[8*i +: 8] = value[8*((int'(phase) + i) % 3) +: 8];
                default: word[8*i +: 8] = value[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/memfill_chan.sv
module memfill_chan
    import memfill_pkg::*;
#(
    parameter int AW  = 16,
    localparam int BAW = AW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_idx,
    input  logic [31:0]    wr_data,
    input  logic [1:0]     rd_idx,
    output logic [31:0]    rd_data,
    output logic           mem_we,
    output logic [BAW-1:0] mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    output logic           irq
);
    typedef struct packed {
        logic [AW-1:0]  first;
        logic [AW-1:0]  limit;
        logic [31:0]    value;
        logic [1:0]     msel;
        logic           run;
        logic           done;
        logic           err;
        logic [BAW-1:0] cur;
        logic [1:0]     phase;
        logic           irq;
    } chan_st_t;

    chan_st_t   st_d, st_q;
    logic [1:0] phase_nxt;
    logic [31:0] word;
    logic [BAW:0] cur_inc;
    logic [BAW:0] limit_byte;

    memfill_lanes u_lanes (
        .mode      (decode_mode(st_q.msel)),
        .value     (st_q.value),
        .phase     (st_q.phase),
        .word      (word),
        .phase_nxt (phase_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        cur_inc    = {1'b0, st_q.cur} + (BAW+1)'(4);
        limit_byte = {1'b0, st_q.limit, 3'b000};
        if (st_q.run) begin
            st_d.cur   = cur_inc[BAW-1:0];
            st_d.phase = phase_nxt;
            if (cur_inc >= limit_byte) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
                st_d.irq  = |st_q.first;
            end
        end else if (wr_en) begin
            case (reg_idx_e'(wr_idx))
                IDX_FIRST: st_d.first = wr_data[AW-1:0];
                IDX_LIMIT: st_d.limit = wr_data[AW-1:0];
                IDX_VALUE: st_d.value = wr_data;
                default: begin
                    st_d.msel = wr_data[9:8];
                    st_d.done = 1'b0;
                    st_d.err  = 1'b0;
                    if (wr_data[0]) begin
                        if (st_q.limit <= st_q.first) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.run   = 1'b1;
                            st_d.cur   = {st_q.first, 3'b000};
                            st_d.phase = 2'd0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_idx_e'(rd_idx))
            IDX_FIRST: rd_data = 32'(st_q.first);
            IDX_LIMIT: rd_data = 32'(st_q.limit);
            IDX_VALUE: rd_data = st_q.value;
            default:   rd_data = {22'd0, st_q.msel, 5'd0, st_q.err, st_q.done, st_q.run};
        endcase
    end

    assign mem_we    = st_q.run;
    assign mem_addr  = st_q.cur;
    assign mem_be    = {4{st_q.run}};
    assign mem_wdata = word;
    assign irq       = st_q.irq;

    // R5: consecutive writes advance by one word
    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + BAW'(4));
    // R1: never writes at or past the limit
    a_r1_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr < {st_q.limit, 3'b000});
    // R7: finished flag only rises right after a write
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(mem_we));
    // R8: interrupt lasts one cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6: an error leaves the port quiet
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !mem_we);
    // R10: registers frozen while filling
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && $past(st_q.run) |-> $stable(st_q.first) && $stable(st_q.limit)
                                         && $stable(st_q.value) && $stable(st_q.msel));
endmodule

// File: rtl/memfill_engine.sv
module memfill_engine
    import memfill_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 16,
    localparam int CSW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BAW   = AW + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [CSW+1:0]        reg_waddr,
    input  logic [31:0]           reg_wdata,
    input  logic [CSW+1:0]        reg_raddr,
    output logic [31:0]           reg_rdata,
    output logic [NUM_CH-1:0]     mem_we,
    output logic [NUM_CH*BAW-1:0] mem_addr,
    output logic [NUM_CH*4-1:0]   mem_be,
    output logic [NUM_CH*32-1:0]  mem_wdata,
    output logic [NUM_CH-1:0]     irq
);
    logic [31:0] ch_rd [NUM_CH];
    logic [CSW-1:0] rsel;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel_wr;
        assign sel_wr = reg_wr && (reg_waddr[CSW+1:2] == CSW'(g));
        memfill_chan #(.AW(AW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_wr),
            .wr_idx    (reg_waddr[1:0]),
            .wr_data   (reg_wdata),
            .rd_idx    (reg_raddr[1:0]),
            .rd_data   (ch_rd[g]),
            .mem_we    (mem_we[g]),
            .mem_addr  (mem_addr[g*BAW +: BAW]),
            .mem_be    (mem_be[g*4 +: 4]),
            .mem_wdata (mem_wdata[g*32 +: 32]),
            .irq       (irq[g])
        );
    end

    assign rsel = reg_raddr[CSW+1:2];

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rsel == CSW'(c)) reg_rdata = ch_rd[c];
    end
endmodule

// File: tb/memfill_engine_tb_top.sv
module memfill_engine_tb_top;
    localparam int BAW = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  mem_we;
    logic [37:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [1:0]  irq;

    always #10 clk = ~clk;

    memfill_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit active = 0;

    // behavioural model per channel
    int          m_first [2];
    int          m_limit [2];
    logic [31:0] m_val   [2];
    logic [1:0]  m_sel   [2];
    bit          running [2];
    bit          m_fin   [2];
    bit          m_err   [2];
    bit          irq_due [2];
    bit          end_due [2];
    logic [63:0] expq [2][$];

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(logic [1:0] sel, logic [31:0] v, int j);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            if (sel[0])      w[8*i +: 8] = v[8*((4*j + i) % 3) +: 8];
            else if (sel[1]) w[8*i +: 8] = v[8*i +: 8];
            else             w[8*i +: 8] = v[8*(i % 2) +: 8];
        end
        return w;
    endfunction

    task automatic wr(int c, int idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = {c[0], idx[1:0]}; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (!running[c]) begin
            case (idx)
                0: m_first[c] = int'(d[15:0]);
                1: m_limit[c] = int'(d[15:0]);
                2: m_val[c] = d;
                default: begin
                    m_sel[c] = d[9:8]; m_fin[c] = 0; m_err[c] = 0;
                    if (d[0]) begin
                        if (m_limit[c] <= m_first[c]) m_err[c] = 1;
                        else begin
                            for (int j = 0; j < (m_limit[c] - m_first[c]) * 2; j++)
                                expq[c].push_back({32'(m_first[c]*8 + 4*j),
                                                   exp_word(m_sel[c], m_val[c], j)});
                            running[c] = 1;
                        end
                    end
                end
            endcase
        end
    endtask

    task automatic rd(int c, int idx, output logic [31:0] d);
        @(negedge clk);
        #2;
        reg_raddr = {c[0], idx[1:0]};
        #1;
        d = reg_rdata;
    endtask

    task automatic check_ctrl(int c, string req);
        logic [31:0] v, e;
        rd(c, 3, v);
        e = {22'd0, m_sel[c], 5'd0, m_err[c], m_fin[c], running[c]};
        check(v == e, req, v, e);
    endtask

    task automatic wait_idle(int c);
        while (running[c]) @(negedge clk);
        @(negedge clk);
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (active) begin
            for (int c = 0; c < 2; c++) begin
                check(irq[c] == irq_due[c], "R8 irq", irq[c], irq_due[c]);
                irq_due[c] = 0;
                if (end_due[c]) begin
                    running[c] = 0; m_fin[c] = 1; end_due[c] = 0;
                end
                check(mem_we[c] == (expq[c].size() > 0), "R5 write strobe",
                      mem_we[c], expq[c].size() > 0);
                if (mem_we[c] && expq[c].size() > 0) begin
                    logic [63:0] e;
                    e = expq[c].pop_front();
                    check(mem_addr[c*BAW +: BAW] == e[32 +: BAW], "R1 address",
                          mem_addr[c*BAW +: BAW], e[32 +: BAW]);
                    check(mem_wdata[c*32 +: 32] == e[31:0], "R2/R3/R4 data",
                          mem_wdata[c*32 +: 32], e[31:0]);
                    check(mem_be[c*4 +: 4] == 4'hF, "R5 byte enables", mem_be[c*4 +: 4], 4'hF);
                    if (expq[c].size() == 0) begin
                        end_due[c] = 1;
                        irq_due[c] = (m_first[c] != 0);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < 2; c++) begin
            m_first[c] = 0; m_limit[c] = 0; m_val[c] = 0; m_sel[c] = 0;
            running[c] = 0; m_fin[c] = 0; m_err[c] = 0; irq_due[c] = 0; end_due[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        active = 1;
        // R11: reset state
        check_ctrl(0, "R11 reset ctrl ch0");
        check_ctrl(1, "R11 reset ctrl ch1");
        rd(0, 0, v); check(v == 0, "R11 reset first", v, 0);

        // R2: 16-bit fill
        wr(0, 0, 2); wr(0, 1, 5); wr(0, 2, 32'hAABB1234);
        wr(0, 3, 32'h1);
        check_ctrl(0, "R10 busy reads start bit");
        wait_idle(0);
        check_ctrl(0, "R7 finished after 16-bit fill");

        // R3: 32-bit fill
        wr(0, 0, 1); wr(0, 1, 3); wr(0, 2, 32'hDEADBEEF);
        wr(0, 3, 32'h201);
        wait_idle(0);
        check_ctrl(0, "R3 32-bit done");

        // R4: 24-bit fill on channel 1
        wr(1, 0, 4); wr(1, 1, 7); wr(1, 2, 32'h00332211);
        wr(1, 3, 32'h101);
        wait_idle(1);
        check_ctrl(1, "R4 24-bit done");

        // R3: both mode bits set selects 24-bit
        wr(1, 2, 32'hFFC3B2A1);
        wr(1, 3, 32'h301);
        wait_idle(1);
        check_ctrl(1, "R3 both bits -> 24-bit");

        // R7/R8: first address zero, no interrupt but finished
        wr(0, 0, 0); wr(0, 1, 2); wr(0, 2, 32'h0000CAFE);
        wr(0, 3, 32'h1);
        wait_idle(0);
        check_ctrl(0, "R7 finished with zero first address");

        // R6: equal and inverted ranges
        wr(0, 0, 6); wr(0, 1, 6); wr(0, 3, 32'h1);
        repeat (3) @(negedge clk);
        check_ctrl(0, "R6 equal range error");
        wr(0, 1, 3); wr(0, 3, 32'h201);
        repeat (3) @(negedge clk);
        check_ctrl(0, "R6 inverted range error");
        // R11: idle control write clears error
        wr(0, 3, 32'h100);
        check_ctrl(0, "R11 ctrl write clears flags");

        // R10: writes ignored while busy
        wr(0, 0, 1); wr(0, 1, 20); wr(0, 2, 32'h5A5A1111);
        wr(0, 3, 32'h1);
        wr(0, 0, 9); wr(0, 1, 10); wr(0, 2, 32'h77777777); wr(0, 3, 32'h201);
        check_ctrl(0, "R10 busy control");
        wait_idle(0);
        rd(0, 0, v); check(v == 1, "R10 first unchanged", v, 1);
        rd(0, 1, v); check(v == 20, "R10 limit unchanged", v, 20);
        rd(0, 2, v); check(v == 32'h5A5A1111, "R10 value unchanged", v, 32'h5A5A1111);
        check_ctrl(0, "R10 mode unchanged");

        // R9: both channels at once
        wr(0, 0, 3); wr(0, 1, 9); wr(0, 2, 32'h0BADF00D);
        wr(1, 0, 2); wr(1, 1, 8); wr(1, 2, 32'h00654321);
        wr(0, 3, 32'h201);
        wr(1, 3, 32'h101);
        wait_idle(0);
        wait_idle(1);
        check_ctrl(0, "R9 ch0 done");
        check_ctrl(1, "R9 ch1 done");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule